// File: doc/BRIEF.md
# Power-Mode Sequencer with Divided Bus-Master Clock

This block decides which operating mode a small microcontroller core is in and how fast its bus masters are clocked. It drives two clock enables that are qualified against one base clock. The bus-master enable pulses at a ratio chosen by a 3-bit select field: full rate, or base/2 up to base/32. The peripheral enable always runs at full rate whenever peripherals are clocked at all.

A change to the select field does not act at once. The sequencer waits for the bus-cycle-end strobe, so that an access already in flight completes at the rate it started with. The sleep strobe moves the core into sleep or software standby, depending on the standby-enable, low-speed-enable and watchdog prescaler-select bits. Interrupts bring it back to the clock mode it had before. A reset request or a watchdog overflow overrides everything, returns the core to its reset state and cancels any divided clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A high `rst_req` or `wdt_ovf` at a clock edge sets `mode` to 0 (reset) and clears the applied ratio. In reset both enables are low. The first edge without either input moves `mode` to 1 (high-speed), whatever `clk_sel` holds.
- R2: In high-speed mode (`mode`=1), a nonzero `clk_sel` has no effect until an edge where `bus_end` is high. At that edge `mode` becomes 2 (medium-speed).
- R3: In medium-speed mode, `clk_sel`=0 returns `mode` to 1 only at an edge where `bus_end` is high.
- R4: In medium-speed mode with `clk_sel` code k, for k from 1 to 5, `mst_ce` is high for one cycle in every 2^k. Codes 6 and 7 behave exactly like code 5 (base/32).
- R5: Each applied ratio change, and each wake-up, restarts the divider. Number the cycles after the switching edge from 1. `mst_ce` is then high in cycle n exactly when n is a multiple of 2^k.
- R6: In high-speed mode `mst_ce` is high on every cycle. `per_ce` is high on every cycle in modes 1, 2 and 3.
- R7: In mode 1 or 2, `sleep_stb` with `stby_en`=0 and `lowspd_en`=0 enters sleep (`mode`=3). `mst_ce` stays low while asleep.
- R8: In sleep, `irq` or `ext_irq` returns to the mode that matches the ratio applied before sleep: 1 if that ratio is 0, otherwise 2.
- R9: In mode 1 or 2, `sleep_stb` with `stby_en`=1, `lowspd_en`=0 and `wdt_pss`=0 enters software standby (`mode`=4). Both enables are low there.
- R10: In software standby, `irq` has no effect. Only `ext_irq` wakes the core, into the mode given by the applied ratio, as in R8.
- R11: `sleep_stb` with `lowspd_en`=1, or with `stby_en`=1 and `wdt_pss`=1, is ignored: mode, ratio and divider phase are unchanged.
- R12: Priority is reset, then sleep, then ratio change. When `sleep_stb` and `bus_end` are high in the same cycle, the core sleeps and the select change waits for the first `bus_end` after wake-up. `bus_end` has no effect during sleep or standby.
- R13: A `bus_end` whose select decodes to the ratio already applied (for example code 6 while base/32 is applied) neither changes the mode nor restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous reset request from the reset pins |
| wdt_ovf | input | 1 | Watchdog overflow, forces the reset state |
| clk_sel | input | 3 | Requested master clock ratio code (0 = full rate) |
| stby_en | input | 1 | Standby enable bit |
| lowspd_en | input | 1 | Low-speed enable bit |
| wdt_pss | input | 1 | Watchdog prescaler-select bit |
| sleep_stb | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | End of the current bus cycle |
| irq | input | 1 | Internal interrupt |
| ext_irq | input | 1 | External interrupt |
| mst_ce | output | 1 | Bus-master clock enable at the selected ratio |
| per_ce | output | 1 | Peripheral clock enable, full rate |
| mode | output | 3 | Current mode: 0 reset, 1 high, 2 medium, 3 sleep, 4 standby |

## Verification
The bench holds a nonzero select for several cycles without `bus_end`. A design that switched at once would report medium-speed too early and shift every following `mst_ce` pulse. It drives codes 6 and 7 and re-applies an equal ratio. A design that stalled on an undefined code, or restarted the divider without need, would lose pulses against the reference count. It raises `sleep_stb` and `bus_end` together, sends `irq` into standby, and issues ignored sleep strobes. These catch a design that applies the ratio through sleep, wakes from standby on the wrong interrupt, or sleeps when it should not. A watchdog overflow in medium-speed mode with the select still set must land in high-speed mode. A design that kept the old ratio across reset shows up there.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_RST   = 3'd0,
        MODE_HIGH  = 3'd1,
        MODE_MED   = 3'd2,
        MODE_SLEEP = 3'd3,
        MODE_SSTBY = 3'd4
    } pmode_e;

    function automatic logic mode_running(input pmode_e m);
        return (m == MODE_HIGH) || (m == MODE_MED);
    endfunction

endpackage

// File: rtl/pwr_ratio_dec.sv
module pwr_ratio_dec #(
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 5,
    localparam int RATIO_W = $clog2(MAX_LOG2 + 1)
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [RATIO_W-1:0] ratio
);

    localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_LOG2);

    always_comb begin
        if (sel > SEL_CAP) begin
            ratio = RATIO_W'(MAX_LOG2);
        end else begin
            ratio = RATIO_W'(sel);
        end
    end

endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
    parameter int MAX_LOG2 = 5,
    localparam int RATIO_W = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [RATIO_W-1:0] ratio,
    output logic               ce
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        term = '0;
        for (int b = 0; b < CNT_W; b++) begin
            if (32'(b) < 32'(ratio)) begin
                term[b] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        ce   = run && ((ratio == '0) || (st_q.cnt == term));
        if (restart || !run || ce) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!ce || ratio == '0));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic               wdt_ovf,
    input  logic               stby_en,
    input  logic               lowspd_en,
    input  logic               wdt_pss,
    input  logic               sleep_stb,
    input  logic               bus_end,
    input  logic               irq,
    input  logic               ext_irq,
    input  logic [RATIO_W-1:0] sel_ratio,
    output pmode_e             mode,
    output logic [RATIO_W-1:0] ratio,
    output logic               restart,
    output logic               run
);

    typedef struct packed {
        pmode_e             mode;
        logic [RATIO_W-1:0] ratio;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    pmode_e     wake_mode;
    logic       force_rst;
    logic       go_sleep;
    logic       go_stby;
    logic       ratio_new;

    always_comb begin
        st_d      = st_q;
        restart   = 1'b0;
        force_rst = rst_req || wdt_ovf;
        go_sleep  = sleep_stb && !lowspd_en && !stby_en;
        go_stby   = sleep_stb && !lowspd_en && stby_en && !wdt_pss;
        ratio_new = bus_end && (sel_ratio != st_q.ratio);
        wake_mode = (st_q.ratio == '0) ? MODE_HIGH : MODE_MED;

        if (force_rst) begin
            st_d.mode  = MODE_RST;
            st_d.ratio = '0;
            restart    = 1'b1;
        end else begin
            unique case (st_q.mode)
                MODE_RST: begin
                    st_d.mode = MODE_HIGH;
                    restart   = 1'b1;
                end
                MODE_HIGH, MODE_MED: begin
                    if (go_sleep) begin
                        st_d.mode = MODE_SLEEP;
                    end else if (go_stby) begin
                        st_d.mode = MODE_SSTBY;
                    end else if (ratio_new) begin
                        st_d.ratio = sel_ratio;
                        st_d.mode  = (sel_ratio == '0) ? MODE_HIGH : MODE_MED;
                        restart    = 1'b1;
                    end
                end
                MODE_SLEEP: begin
                    if (irq || ext_irq) begin
                        st_d.mode = wake_mode;
                        restart   = 1'b1;
                    end
                end
                MODE_SSTBY: begin
                    if (ext_irq) begin
                        st_d.mode = wake_mode;
                        restart   = 1'b1;
                    end
                end
                default: begin
                    st_d.mode  = MODE_RST;
                    st_d.ratio = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RST, ratio: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode  = st_q.mode;
    assign ratio = st_q.ratio;
    assign run   = mode_running(st_q.mode);

    // R1
    rst_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wdt_ovf) |=> (mode == MODE_RST && ratio == '0));

    // R2
    hold_until_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HIGH && !bus_end) |=> (mode != MODE_MED));

    // R8
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && (irq || ext_irq) && !rst_req && !wdt_ovf)
        |=> (run && $stable(ratio)));

    // R10
    stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SSTBY && !ext_irq && !rst_req && !wdt_ovf)
        |=> (mode == MODE_SSTBY));

    // R12
    asleep_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && mode != MODE_RST && !rst_req && !wdt_ovf) |=> $stable(ratio));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int MAX_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              wdt_ovf,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              stby_en,
    input  logic              lowspd_en,
    input  logic              wdt_pss,
    input  logic              sleep_stb,
    input  logic              bus_end,
    input  logic              irq,
    input  logic              ext_irq,
    output logic              mst_ce,
    output logic              per_ce,
    output logic [MODE_W-1:0] mode
);

    localparam int RATIO_W = $clog2(MAX_LOG2 + 1);

    logic [RATIO_W-1:0] sel_ratio;
    logic [RATIO_W-1:0] cur_ratio;
    logic               div_restart;
    logic               div_run;
    pmode_e             cur_mode;

    pwr_ratio_dec #(
        .SEL_W    (SEL_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_dec (
        .sel   (clk_sel),
        .ratio (sel_ratio)
    );

    pwr_mode_fsm #(
        .RATIO_W (RATIO_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .wdt_ovf   (wdt_ovf),
        .stby_en   (stby_en),
        .lowspd_en (lowspd_en),
        .wdt_pss   (wdt_pss),
        .sleep_stb (sleep_stb),
        .bus_end   (bus_end),
        .irq       (irq),
        .ext_irq   (ext_irq),
        .sel_ratio (sel_ratio),
        .mode      (cur_mode),
        .ratio     (cur_ratio),
        .restart   (div_restart),
        .run       (div_run)
    );

    pwr_clk_div #(
        .MAX_LOG2 (MAX_LOG2)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (div_run),
        .restart (div_restart),
        .ratio   (cur_ratio),
        .ce      (mst_ce)
    );

    assign per_ce = div_run || (cur_mode == MODE_SLEEP);
    assign mode   = cur_mode;

    // R9
    stby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_SSTBY) |-> (!per_ce && !mst_ce));

    // R6
    high_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_HIGH) |-> (mst_ce && per_ce));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0, wdt_ovf = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       stby_en = 1'b0, lowspd_en = 1'b0, wdt_pss = 1'b0;
    logic       sleep_stb = 1'b0, bus_end = 1'b0, irq = 1'b0, ext_irq = 1'b0;
    logic       mst_ce, per_ce;
    logic [2:0] mode;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    int m_mode  = 0;
    int m_ratio = 0;
    int m_since = 1;

    always #10 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .wdt_ovf(wdt_ovf),
        .clk_sel(clk_sel), .stby_en(stby_en), .lowspd_en(lowspd_en),
        .wdt_pss(wdt_pss), .sleep_stb(sleep_stb), .bus_end(bus_end),
        .irq(irq), .ext_irq(ext_irq), .mst_ce(mst_ce), .per_ce(per_ce),
        .mode(mode)
    );

    function automatic int code_to_log2(input int code);
        return (code > 5) ? 5 : code;
    endfunction

    function automatic int wake_to();
        return (m_ratio == 0) ? 1 : 2;
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n || rst_req || wdt_ovf) begin
            m_mode = 0; m_ratio = 0; m_since = 1;
        end else if (m_mode == 0) begin
            m_mode = 1; m_since = 1;
        end else if (m_mode == 1 || m_mode == 2) begin
            if (sleep_stb && !lowspd_en && !stby_en) m_mode = 3;
            else if (sleep_stb && !lowspd_en && stby_en && !wdt_pss) m_mode = 4;
            else if (bus_end && code_to_log2(int'(clk_sel)) != m_ratio) begin
                m_ratio = code_to_log2(int'(clk_sel));
                m_mode  = (m_ratio == 0) ? 1 : 2;
                m_since = 1;
            end else m_since = m_since + 1;
        end else if (m_mode == 3) begin
            if (irq || ext_irq) begin m_mode = wake_to(); m_since = 1; end
        end else if (m_mode == 4) begin
            if (ext_irq) begin m_mode = wake_to(); m_since = 1; end
        end
    end

    function automatic logic exp_mst();
        if (m_mode == 1) return 1'b1;
        if (m_mode == 2) return (m_since % (1 << m_ratio)) == 0;
        return 1'b0;
    endfunction

    task automatic check(input string t, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        check({tag, " mode"}, int'(mode), m_mode);
        check({tag, " mst_ce"}, int'(mst_ce), int'(exp_mst()));
        check({tag, " per_ce"}, int'(per_ce), int'(m_mode >= 1 && m_mode <= 3));
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bus_end();
        bus_end = 1'b1; @(negedge clk); bus_end = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_stb = 1'b1; @(negedge clk); sleep_stb = 1'b0;
    endtask

    task automatic count_ce(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            cnt += int'(mst_ce);
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        int cnt;
        // R1 reset state and release
        tag = "R1";
        idle(3);
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset per_ce", int'(per_ce), 0);
        rst_n = 1'b1;
        idle(1);
        check("R1 release to high", int'(mode), 1);
        // R6 high-speed full rate
        tag = "R6";
        idle(5);
        check("R6 mst_ce high", int'(mst_ce), 1);
        // R2 switch waits for bus_end
        tag = "R2";
        clk_sel = 3'd2;
        idle(6);
        check("R2 still high", int'(mode), 1);
        pulse_bus_end();
        check("R2 medium after bus_end", int'(mode), 2);
        // R4 R5 base/4: pulses in cycles 4,8,12,16
        tag = "R5";
        count_ce(16, cnt);
        check("R4 R5 pulses at /4", cnt, 4);
        // R13 same ratio: no restart
        tag = "R13";
        idle(1);
        pulse_bus_end();
        idle(9);
        // R4 code 7 acts as /32
        tag = "R4";
        clk_sel = 3'd7;
        pulse_bus_end();
        count_ce(64, cnt);
        check("R4 code7 pulses", cnt, 2);
        tag = "R13";
        idle(5);
        clk_sel = 3'd6;
        pulse_bus_end();
        count_ce(27, cnt);
        check("R13 code6 no restart", cnt, 1);
        // R7 sleep, R12 bus_end ignored while asleep, R8 wake restores /2
        tag = "R7";
        clk_sel = 3'd1;
        pulse_bus_end();
        idle(3);
        pulse_sleep();
        check("R7 sleep mode", int'(mode), 3);
        tag = "R12";
        clk_sel = 3'd3;
        pulse_bus_end();
        idle(4);
        check("R12 still asleep", int'(mode), 3);
        check("R7 mst_ce low", int'(mst_ce), 0);
        tag = "R8";
        irq = 1'b1; @(negedge clk); irq = 1'b0;
        check("R8 back to medium", int'(mode), 2);
        count_ce(8, cnt);
        check("R8 ratio /2 kept", cnt, 4);
        pulse_bus_end();
        idle(10);
        // R12 sleep and bus_end together: sleep wins
        tag = "R12";
        clk_sel = 3'd0;
        sleep_stb = 1'b1; bus_end = 1'b1;
        @(negedge clk);
        sleep_stb = 1'b0; bus_end = 1'b0;
        check("R12 sleep wins", int'(mode), 3);
        ext_irq = 1'b1; @(negedge clk); ext_irq = 1'b0;
        check("R12 wake keeps medium", int'(mode), 2);
        // R3 return to high only at bus_end
        tag = "R3";
        idle(5);
        check("R3 waits for bus_end", int'(mode), 2);
        pulse_bus_end();
        check("R3 back to high", int'(mode), 1);
        // R11 ignored sleep strobes
        tag = "R11";
        lowspd_en = 1'b1;
        pulse_sleep();
        check("R11 lowspd ignored", int'(mode), 1);
        lowspd_en = 1'b0; stby_en = 1'b1; wdt_pss = 1'b1;
        pulse_sleep();
        check("R11 pss ignored", int'(mode), 1);
        wdt_pss = 1'b0;
        // R9 standby, R10 irq ignored
        tag = "R9";
        pulse_sleep();
        check("R9 standby mode", int'(mode), 4);
        check("R9 per_ce low", int'(per_ce), 0);
        tag = "R10";
        irq = 1'b1; idle(3); irq = 1'b0;
        check("R10 irq ignored", int'(mode), 4);
        ext_irq = 1'b1; @(negedge clk); ext_irq = 1'b0;
        check("R10 ext wake", int'(mode), 1);
        stby_en = 1'b0;
        // R1 watchdog cancels medium-speed
        tag = "R1";
        clk_sel = 3'd4;
        pulse_bus_end();
        idle(7);
        wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
        check("R1 wdt reset", int'(mode), 0);
        idle(1);
        check("R1 medium cancelled", int'(mode), 1);
        idle(4);
        pulse_bus_end();
        check("R1 medium again", int'(mode), 2);
        // R1 reset request from sleep
        pulse_sleep();
        rst_req = 1'b1; idle(2); rst_req = 1'b0;
        check("R1 rst from sleep", int'(mode), 0);
        idle(3);
        finish_up();
    end

endmodule